// File: doc/BRIEF.md
# Parallel SAR ADC Host Sequencer

This block sits on the host side of a successive-approximation converter that has a shared 15-bit parallel data bus. When the user asks for a sample, or keeps continuous mode on, the sequencer pulses the active-low conversion-start line. It then waits for the converter's busy line to go low and come back high. After that it asserts chip-select and read together and captures the 14-bit result and the overrange bit. It then presents them for one cycle on a sample-valid output.

The user can also load a signed offset-calibration value at any time. The sequencer saturates the value to the legal range of -1310 to +1310 and packs it into a 15-bit word. It writes that word to the converter only between conversions. A request that arrives during a conversion is held and written after the read. Every read or write strobe is followed by a quiet gap before the next conversion start. All strobe widths, the quiet gap and the busy timeout are clock-cycle parameters. The bus is split into an output word, an output-enable and an input word, so that a pad ring can build the three-state pin.

Top module: `adc_host_seq`

## Requirements
- R1: After reset the start, chip-select, read and write strobes are all high, the bus output-enable is low and `smp_valid` is low.
- R2: A single-cycle `conv_req` leads to exactly one low pulse on `adc_convst_n`, which lasts exactly `T_START` cycles.
- R3: Once `adc_busy` has been seen low and then high after a start, `adc_cs_n` and `adc_rd_n` are low together for exactly `T_RD` cycles. The bus is sampled in the last read cycle. In the next cycle `smp_valid` pulses high for one cycle, with `smp_data` = bus bits 13..0 and `smp_ovr` = bus bit 14.
- R4: A requested offset above +1310 is written as +1310 and one below -1310 is written as -1310. `ofs_clamped` is high in the cycle after the request exactly when saturation occurred.
- R5: An offset write holds `adc_wr_n` and `adc_cs_n` low for exactly `T_WR` cycles. It drives `{3'b000, offset[11:0]}` on the bus, with the offset in 12-bit two's complement.
- R6: The bus output-enable is high only while the write strobe is low.
- R7: No write strobe occurs between the fall of `adc_convst_n` and the read of that conversion. A request made during that window is written after the read and before the next start.
- R8: At least `T_QUIET` cycles with all read and write strobes high pass between the end of any read or write strobe and the next fall of `adc_convst_n`.
- R9: While `cont_mode` is high, conversions repeat with no further `conv_req`.
- R10: If `adc_busy` has not completed its low-then-high handshake within `T_TIMEOUT` cycles of the start pulse ending, `busy_timeout` pulses for one cycle and no sample is produced. Later conversions still work.
- R11: Read and write strobes are never low together, and chip-select is high while the start line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_req | input | 1 | Request one conversion |
| cont_mode | input | 1 | Convert back-to-back while high |
| ofs_req | input | 1 | Load offset request |
| ofs_value | input | OFS_IN_W | Requested offset, signed |
| smp_valid | output | 1 | Result strobe, one cycle |
| smp_data | output | 14 | Conversion result |
| smp_ovr | output | 1 | Overrange flag of result |
| ofs_clamped | output | 1 | Offset was saturated, one cycle |
| busy_timeout | output | 1 | Busy handshake timed out, one cycle |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_dq_i | input | 15 | Bus value from the pad |
| adc_dq_o | output | 15 | Bus value to drive |
| adc_dq_oe | output | 1 | Bus output enable |

## Verification
The assertions assume that `adc_busy` is synchronous to `clk`. They also assume that busy drops only after a start pulse and returns high before the next start is requested, so a stale low from a hung conversion never carries into a new one. They further assume that two offset requests are not stacked while one is pending. The bench's converter model drives busy low on the cycle after the start edge and raises it a fixed number of cycles later. In the timeout case it holds busy low until the sequencer gives up, and it releases busy before the next request. Offset requests are issued one at a time, each after the previous write has finished.

// File: rtl/ahs_pkg.sv
// Shared types and constants for the parallel ADC host sequencer.
// Assumes a 15-bit converter bus: 14 result bits plus an overrange bit.
package ahs_pkg;
    localparam int DQ_W  = 15;
    localparam int RES_W = 14;
    localparam int OFS_W = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_QUIET
    } ahs_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ahs_offset_prep.sv
// Saturates a signed offset request to +/-LIMIT and packs it into the
// bus word: zero upper bits, 12-bit two's complement below.
// Assumes LIMIT fits in OFS_W-bit two's complement.
module ahs_offset_prep
    import ahs_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int LIMIT = 1310
) (
    input  logic signed [IN_W-1:0] raw,
    output logic [DQ_W-1:0]        word,
    output logic                   clamped
);
    localparam logic signed [IN_W-1:0] LIM_P = IN_W'(LIMIT);
    localparam logic signed [IN_W-1:0] LIM_N = -LIM_P;

    logic signed [IN_W-1:0] sat;

    // Saturate to the legal range and flag when it happened.
    always_comb begin
        clamped = 1'b1;
        if (raw > LIM_P)      sat = LIM_P;
        else if (raw < LIM_N) sat = LIM_N;
        else begin
            sat     = raw;
            clamped = 1'b0;
        end
        word = {{(DQ_W-OFS_W){1'b0}}, sat[OFS_W-1:0]};
    end
endmodule

// File: rtl/ahs_timer.sv
// Down counter used to time every sequencer phase.
// Assumes the caller loads (length - 1) on the first cycle of a phase.
module ahs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_host_seq.sv
// Host sequencer for a parallel-bus SAR converter: start pulse, busy
// handshake, read strobe, offset write between conversions, quiet gap.
// Assumes adc_busy is synchronous to clk. All T_* parameters are >= 1.
module adc_host_seq
    import ahs_pkg::*;
#(
    parameter int T_START   = 3,
    parameter int T_RD      = 4,
    parameter int T_WR      = 3,
    parameter int T_QUIET   = 5,
    parameter int T_TIMEOUT = 64,
    parameter int OFS_IN_W  = 16,
    parameter int OFS_LIMIT = 1310
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       conv_req,
    input  logic                       cont_mode,
    input  logic                       ofs_req,
    input  logic signed [OFS_IN_W-1:0] ofs_value,
    output logic                       smp_valid,
    output logic [13:0]                smp_data,
    output logic                       smp_ovr,
    output logic                       ofs_clamped,
    output logic                       busy_timeout,
    output logic                       adc_convst_n,
    output logic                       adc_cs_n,
    output logic                       adc_rd_n,
    output logic                       adc_wr_n,
    input  logic                       adc_busy,
    input  logic [14:0]                adc_dq_i,
    output logic [14:0]                adc_dq_o,
    output logic                       adc_dq_oe
);
    localparam int T_MAX = imax(imax(imax(T_START, T_RD), imax(T_WR, T_QUIET)), T_TIMEOUT);
    localparam int CNT_W = $clog2(T_MAX + 1);

    ahs_state_t       st, st_nxt;
    logic             tz, t_load;
    logic [CNT_W-1:0] t_val;
    logic             ofs_pend, conv_pend, seen_low, to_hit;
    logic [DQ_W-1:0]  prep_word, pend_word, wr_word;
    logic             prep_clamped;

    ahs_offset_prep #(.IN_W(OFS_IN_W), .LIMIT(OFS_LIMIT)) u_prep (
        .raw     (ofs_value),
        .word    (prep_word),
        .clamped (prep_clamped)
    );

    ahs_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (tz)
    );

    // Next phase: pending offset writes win over new conversions.
    always_comb begin
        st_nxt = st;
        to_hit = 1'b0;
        case (st)
            S_IDLE:  if (ofs_pend) st_nxt = S_WRITE;
                     else if (conv_pend || cont_mode) st_nxt = S_START;
            S_START: if (tz) st_nxt = S_WAIT;
            S_WAIT:  if (seen_low && adc_busy) st_nxt = S_READ;
                     else if (tz) begin
                         st_nxt = S_QUIET;
                         to_hit = 1'b1;
                     end
            S_READ:  if (tz) st_nxt = S_QUIET;
            S_WRITE: if (tz) st_nxt = S_QUIET;
            S_QUIET: if (tz) st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // Timer reload value for the phase being entered.
    always_comb begin
        t_load = (st_nxt != st);
        case (st_nxt)
            S_START: t_val = CNT_W'(T_START - 1);
            S_WAIT:  t_val = CNT_W'(T_TIMEOUT - 1);
            S_READ:  t_val = CNT_W'(T_RD - 1);
            S_WRITE: t_val = CNT_W'(T_WR - 1);
            S_QUIET: t_val = CNT_W'(T_QUIET - 1);
            default: t_val = '0;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    // Hold offset requests until the bus is free between conversions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_pend  <= 1'b0;
            pend_word <= '0;
        end else if (ofs_req) begin
            ofs_pend  <= 1'b1;
            pend_word <= prep_word;
        end else if (st == S_IDLE && st_nxt == S_WRITE) begin
            ofs_pend  <= 1'b0;
        end
    end

    // Freeze the word that is driven for the whole write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   wr_word <= '0;
        else if (st == S_IDLE && st_nxt == S_WRITE)   wr_word <= pend_word;
    end

    // Remember a single conversion request until it starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 conv_pend <= 1'b0;
        else if (conv_req)                          conv_pend <= 1'b1;
        else if (st == S_IDLE && st_nxt == S_START) conv_pend <= 1'b0;
    end

    // Track the low half of the busy handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || st == S_IDLE)                       seen_low <= 1'b0;
        else if ((st == S_START || st == S_WAIT) && !adc_busy) seen_low <= 1'b1;
    end

    // Capture the result in the last read cycle and report it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
            smp_ovr   <= 1'b0;
        end else begin
            smp_valid <= (st == S_READ) && tz;
            if (st == S_READ && tz) begin
                smp_data <= adc_dq_i[RES_W-1:0];
                smp_ovr  <= adc_dq_i[RES_W];
            end
        end
    end

    // One-cycle flags for saturation and busy timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_clamped  <= 1'b0;
            busy_timeout <= 1'b0;
        end else begin
            ofs_clamped  <= ofs_req && prep_clamped;
            busy_timeout <= to_hit;
        end
    end

    assign adc_convst_n = (st != S_START);
    assign adc_cs_n     = !(st == S_READ || st == S_WRITE);
    assign adc_rd_n     = (st != S_READ);
    assign adc_wr_n     = (st != S_WRITE);
    assign adc_dq_oe    = (st == S_WRITE);
    assign adc_dq_o     = adc_dq_oe ? wr_word : '0;
endmodule

// File: rtl/ahs_checker.sv
// Protocol checker for adc_host_seq, attached with bind.
// Assumes the converter behaves as described in the brief.
module ahs_checker #(
    parameter int T_QUIET   = 5,
    parameter int OFS_LIMIT = 1310
) (
    input logic        clk,
    input logic        rst_n,
    input logic        adc_convst_n,
    input logic        adc_cs_n,
    input logic        adc_rd_n,
    input logic        adc_wr_n,
    input logic [14:0] adc_dq_o,
    input logic        adc_dq_oe,
    input logic        smp_valid,
    input logic        busy_timeout
);
    logic [15:0] qcnt;
    logic        in_conv;

    // Count idle bus cycles since the last read or write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                     qcnt <= 16'(T_QUIET);
        else if (!adc_rd_n || !adc_wr_n) qcnt <= '0;
        else if (qcnt < 16'(T_QUIET))    qcnt <= qcnt + 1'b1;
    end

    // Mark the span from a start pulse to its read or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                         in_conv <= 1'b0;
        else if (!adc_convst_n)             in_conv <= 1'b1;
        else if (!adc_rd_n || busy_timeout) in_conv <= 1'b0;
    end

    assert_oe_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_dq_oe |-> (!adc_wr_n && !adc_cs_n));
    assert_write_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> (adc_dq_oe && adc_dq_o[14:12] == 3'b000));
    assert_offset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_dq_oe |-> ($signed(adc_dq_o[11:0]) <= OFS_LIMIT && $signed(adc_dq_o[11:0]) >= -OFS_LIMIT));
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> adc_wr_n);
    assert_start_no_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_convst_n |-> adc_cs_n);
    assert_no_write_in_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_conv |-> adc_wr_n);
    assert_quiet_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> (qcnt >= 16'(T_QUIET)));
    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    assert_timeout_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_timeout |=> !busy_timeout);
endmodule

bind adc_host_seq ahs_checker #(.T_QUIET(T_QUIET), .OFS_LIMIT(OFS_LIMIT)) u_ahs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_convst_n (adc_convst_n),
    .adc_cs_n     (adc_cs_n),
    .adc_rd_n     (adc_rd_n),
    .adc_wr_n     (adc_wr_n),
    .adc_dq_o     (adc_dq_o),
    .adc_dq_oe    (adc_dq_oe),
    .smp_valid    (smp_valid),
    .busy_timeout (busy_timeout)
);

// File: tb/adc_host_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the converter model and the offset driver queue
// expected items; monitors pop and compare them as the design works.
module adc_host_seq_bench;
    localparam int T_START = 3, T_RD = 4, T_WR = 3, T_QUIET = 5, T_TIMEOUT = 64;
    localparam int CONV_CYC = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, conv_req, cont_mode, ofs_req;
    logic signed [15:0] ofs_value;
    logic smp_valid, smp_ovr, ofs_clamped, busy_timeout;
    logic [13:0] smp_data;
    logic adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n, adc_busy, adc_dq_oe;
    logic [14:0] adc_dq_i, adc_dq_o;

    adc_host_seq #(.T_START(T_START), .T_RD(T_RD), .T_WR(T_WR), .T_QUIET(T_QUIET),
                   .T_TIMEOUT(T_TIMEOUT)) u_adc_host_seq (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cont_mode(cont_mode),
        .ofs_req(ofs_req), .ofs_value(ofs_value), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_ovr(smp_ovr), .ofs_clamped(ofs_clamped),
        .busy_timeout(busy_timeout), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_busy(adc_busy),
        .adc_dq_i(adc_dq_i), .adc_dq_o(adc_dq_o), .adc_dq_oe(adc_dq_oe)
    );

    int n_chk = 0, n_fail = 0;
    logic [14:0] exp_q[$];
    logic [14:0] ofs_q[$];
    logic [14:0] cur_res = '0;
    bit hang = 0;
    int conv_cnt = 0, smp_cnt = 0, wr_done = 0, to_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] pattern(input int n);
        if (n == 0) return 15'h0000;
        if (n == 1) return 15'h7FFF;
        return {n[0], 14'(n * 4919 + 37)};
    endfunction

    function automatic logic [14:0] exp_word(input int v);
        int s;
        s = (v > 1310) ? 1310 : ((v < -1310) ? -1310 : v);
        return {3'b000, 12'(s)};
    endfunction

    // Converter model: bus reads return the current result, else junk.
    assign adc_dq_i = (!adc_cs_n && !adc_rd_n) ? cur_res : 15'h2A55;

    // Converter model: busy handshake following each start edge.
    initial begin
        adc_busy = 1'b1;
        forever begin
            @(negedge adc_convst_n);
            @(negedge clk);
            adc_busy = 1'b0;
            cur_res = pattern(conv_cnt);
            conv_cnt++;
            if (!hang) exp_q.push_back(cur_res);
            repeat (CONV_CYC) @(negedge clk);
            while (hang) @(negedge clk);
            adc_busy = 1'b1;
        end
    end

    // Monitors: results, strobe widths, offset words, ordering, quiet gap.
    int cl = 0, rl = 0, wl = 0, qc = 1000;
    bit act = 0, in_conv = 0, conv_prev = 1;
    logic [14:0] wword;
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid) begin
                smp_cnt++;
                if (exp_q.size() == 0) chk(0, "R3 unexpected sample", {smp_ovr, smp_data}, 0);
                else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    chk({smp_ovr, smp_data} == e, "R3 sample value", {smp_ovr, smp_data}, e);
                end
            end
            if (busy_timeout) to_cnt++;
            if (!adc_convst_n) cl++;
            else if (cl != 0) begin
                chk(cl == T_START, "R2 start width", cl, T_START);
                cl = 0;
            end
            if (!adc_rd_n) begin
                rl++;
                if (adc_cs_n) chk(0, "R3 cs with read", adc_cs_n, 0);
            end else if (rl != 0) begin
                chk(rl == T_RD, "R3 read width", rl, T_RD);
                rl = 0;
            end
            if (!adc_wr_n) begin
                wl++;
                wword = adc_dq_o;
                if (!adc_dq_oe || adc_cs_n) chk(0, "R5 oe/cs in write", {adc_dq_oe, adc_cs_n}, 2'b10);
            end else if (wl != 0) begin
                chk(wl == T_WR, "R5 write width", wl, T_WR);
                if (ofs_q.size() == 0) chk(0, "R5 unexpected write", wword, 0);
                else begin
                    logic [14:0] e;
                    e = ofs_q.pop_front();
                    chk(wword == e, "R5 offset word", wword, e);
                end
                wl = 0;
                wr_done++;
            end
            if (adc_dq_oe && adc_wr_n) chk(0, "R6 oe outside write", adc_dq_oe, 0);
            if ((!adc_rd_n && !adc_wr_n) || (!adc_convst_n && !adc_cs_n))
                chk(0, "R11 strobe overlap", {adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n}, 0);
            if (!adc_convst_n) in_conv = 1;
            else if (!adc_rd_n || busy_timeout) in_conv = 0;
            if (!adc_wr_n && in_conv) chk(0, "R7 write during conversion", adc_wr_n, 1);
            if (!adc_rd_n || !adc_wr_n) begin
                qc = 0;
                act = 1;
            end else if (!adc_convst_n && conv_prev) begin
                if (act) chk(qc >= T_QUIET, "R8 quiet gap", qc, T_QUIET);
            end else qc++;
            conv_prev = adc_convst_n;
        end
    end

    task automatic wait_idle();
        int calm = 0;
        while (calm < T_QUIET + 4) begin
            @(negedge clk);
            if (adc_convst_n && adc_cs_n && adc_rd_n && adc_wr_n && adc_busy) calm++;
            else calm = 0;
        end
    endtask

    task automatic do_conv();
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        wait_idle();
    endtask

    task automatic do_ofs(input int v, input bit exp_cl);
        @(negedge clk);
        ofs_value = 16'(v);
        ofs_req = 1'b1;
        ofs_q.push_back(exp_word(v));
        @(negedge clk);
        ofs_req = 1'b0;
        chk(ofs_clamped == exp_cl, "R4 clamp flag", ofs_clamped, exp_cl);
        @(negedge clk);
        chk(ofs_clamped == 1'b0, "R4 clamp flag one cycle", ofs_clamped, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base, lim;
        rst_n = 1'b0; conv_req = 1'b0; cont_mode = 1'b0; ofs_req = 1'b0; ofs_value = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n} == 4'hF, "R1 strobes idle",
            {adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n}, 4'hF);
        chk(adc_dq_oe == 1'b0, "R1 oe low", adc_dq_oe, 0);
        chk(smp_valid == 1'b0, "R1 no sample", smp_valid, 0);

        // R2 R3 single conversions with all-zero, all-one and mixed results
        for (int i = 0; i < 4; i++) do_conv();
        chk(smp_cnt == 4, "R3 sample count", smp_cnt, 4);

        // R4 R5 offset writes while idle
        do_ofs(256, 0);   wait_idle();
        do_ofs(-512, 0);  wait_idle();
        do_ofs(2000, 1);  wait_idle();
        do_ofs(-3000, 1); wait_idle();
        do_ofs(1310, 0);  wait_idle();
        do_ofs(-1310, 0); wait_idle();
        do_ofs(1311, 1);  wait_idle();
        chk(wr_done == 7, "R5 write count", wr_done, 7);

        // R7 offset request during a conversion is deferred
        base = wr_done;
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        while (adc_busy) @(negedge clk);
        do_ofs(-100, 0);
        chk(wr_done == base, "R7 no write while converting", wr_done, base);
        wait_idle();
        chk(wr_done == base + 1, "R7 deferred write done", wr_done, base + 1);

        // R9 continuous mode
        base = smp_cnt;
        cont_mode = 1'b1;
        lim = 0;
        while (smp_cnt < base + 4 && lim < 2000) begin
            @(negedge clk);
            lim++;
        end
        cont_mode = 1'b0;
        wait_idle();
        chk(smp_cnt >= base + 4, "R9 continuous samples", smp_cnt, base + 4);

        // R10 busy timeout
        base = smp_cnt;
        hang = 1;
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        lim = 0;
        while (!busy_timeout && lim < T_TIMEOUT + 50) begin
            @(negedge clk);
            lim++;
        end
        chk(busy_timeout == 1'b1, "R10 timeout flagged", busy_timeout, 1);
        @(negedge clk);
        chk(busy_timeout == 1'b0, "R10 timeout one cycle", busy_timeout, 0);
        chk(smp_cnt == base, "R10 no sample on timeout", smp_cnt, base);
        hang = 0;
        wait_idle();
        do_conv();
        chk(smp_cnt == base + 1, "R10 recovers after timeout", smp_cnt, base + 1);
        chk(to_cnt == 1, "R10 timeout count", to_cnt, 1);

        chk(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
        chk(ofs_q.size() == 0, "R5 all offsets written", ofs_q.size(), 0);
        finish_run();
    end
endmodule